// File: doc/BRIEF.md
# Network Controller Control/Status Register Block

This block is the software-facing register front end of an Ethernet controller. A processor reaches four 16-bit registers through two bus locations. One location holds a register pointer. The other reads or writes whichever register the pointer selects. Register 0 is the command and status word. It collects completion and error events from the transmit, receive and initialization engines. It holds the command bits that start those engines. It also drives one interrupt line. Registers 1 to 3 are plain storage, which the engines use for their setup values.

The command/status word gives different bits different write rules. Status flags clear when software writes a one to them. Command flags can be set by software but not cleared by it. A stop command beats the other commands. The interrupt enable takes whatever value is written. Two summary bits are recomputed from the status flags on every update. A memory error shuts both data paths off. The stop state keeps the init-done flag clear.

Top module: `nic_csr_block`

## Requirements
- R1: A write to bus location 1 loads the register pointer with the low 2 bits of the write data; a read of location 1 returns the pointer zero-extended. Location 0 reads or writes the register the pointer selects.
- R2: Registers 1, 2 and 3 are 16-bit read/write storage that reset to 0.
- R3: After reset, register 0 reads 0x0004 (only STOP set) and `irq` is low.
- R4: Status flags BABL (bit 14), CERR (13), MISS (12), MERR (11), RINT (10), TINT (9) and IDON (8) clear when a one is written at their position, and writing zero there leaves them alone. Engine events set BABL..TINT. An event in the same cycle as a clear write leaves the flag set.
- R5: TDMD (bit 3), STRT (bit 1) and INIT (bit 0) are set by writing one and are not cleared by writing zero. Setting STRT or INIT clears STOP (bit 2). The transmit poll-acknowledge event clears TDMD.
- R6: Writing one to STOP sets STOP and clears STRT and INIT, even when STRT or INIT are set in the same word.
- R7: INEA (bit 6) takes the written value on every write to register 0.
- R8: ERR (bit 15) equals the OR of BABL, CERR, MISS and MERR. Writes to bits 15, 7, 5 and 4 have no direct effect.
- R9: INTR (bit 7) equals the OR of BABL, MISS, MERR, RINT, TINT and IDON (CERR excluded). `irq` is high exactly when INTR and INEA are both set.
- R10: An init-done event while INIT is set sets IDON and clears INIT. It sets RXON (bit 5) unless `init_mode[0]` is 1 and TXON (bit 4) unless `init_mode[1]` is 1. An init-done event while INIT is clear changes nothing.
- R11: While MERR is set, RXON and TXON are clear. While STOP is set, IDON is clear.
- R12: `bus_rdata` is registered: it shows, one cycle later, the value of the location addressed in the previous cycle, as it stood before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0: data port, 1: register pointer |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| evt_babble | input | 1 | Transmit babble error event |
| evt_coll_err | input | 1 | Collision/heartbeat error event |
| evt_missed | input | 1 | Missed frame event |
| evt_mem_err | input | 1 | Memory access error event |
| evt_rx_done | input | 1 | Receive complete event |
| evt_tx_done | input | 1 | Transmit complete event |
| evt_init_done | input | 1 | Initialization engine finished |
| evt_poll_ack | input | 1 | Transmit engine accepted the demand |
| init_mode | input | 2 | Mode word bits: [0] receiver disabled, [1] transmitter disabled |
| cmd_start | output | 1 | STRT command level |
| cmd_init | output | 1 | INIT command level |
| cmd_tx_demand | output | 1 | TDMD command level |
| stopped | output | 1 | STOP state |
| rx_enable | output | 1 | Receiver run enable (RXON) |
| tx_enable | output | 1 | Transmitter run enable (TXON) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that events are single-cycle levels sampled on the clock edge. They assume no write reaches register 0 while reset is high. They also assume that `init_mode` is stable in the cycle `evt_init_done` is raised. The stimulus always drives inputs on the falling edge and returns events to zero after each step. It raises init-done with a defined mode value, both while INIT is set and while it is clear. Overlap cases are placed on purpose in one cycle: a clear write with a set event, and STOP with STRT and INIT.

// File: rtl/nic_csr_pkg.sv
`timescale 1ns/1ps
package nic_csr_pkg;
  localparam int CSR_W  = 16;

  // bit positions inside register 0
  localparam int B_ERR  = 15;
  localparam int B_BABL = 14;
  localparam int B_CERR = 13;
  localparam int B_MISS = 12;
  localparam int B_MERR = 11;
  localparam int B_RINT = 10;
  localparam int B_TINT = 9;
  localparam int B_IDON = 8;
  localparam int B_INTR = 7;
  localparam int B_INEA = 6;
  localparam int B_RXON = 5;
  localparam int B_TXON = 4;
  localparam int B_TDMD = 3;
  localparam int B_STOP = 2;
  localparam int B_STRT = 1;
  localparam int B_INIT = 0;

  // flags cleared by writing one
  localparam logic [CSR_W-1:0] W1C_MASK = 16'h7F00;
  // flags raised by engine events
  localparam logic [CSR_W-1:0] EVT_MASK = 16'h7E00;
  // value after reset
  localparam logic [CSR_W-1:0] CSR0_RESET = 16'h0004;
endpackage

// File: rtl/nic_csr_primary.sv
`timescale 1ns/1ps
module nic_csr_primary
  import nic_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wdata,
  input  logic [CSR_W-1:0] evt_vec,
  input  logic             init_done,
  input  logic             poll_ack,
  input  logic [1:0]       mode,
  output logic [CSR_W-1:0] csr_q,
  output logic             irq_q
);
  logic [CSR_W-1:0] nxt;

  always_comb begin
    nxt = csr_q;
    if (poll_ack)
      nxt[B_TDMD] = 1'b0;
    if (wr_en) begin
      nxt = nxt & ~(wdata & W1C_MASK);
      nxt[B_TDMD] = nxt[B_TDMD] | wdata[B_TDMD];
      if (wdata[B_STRT]) begin
        nxt[B_STRT] = 1'b1;
        nxt[B_STOP] = 1'b0;
      end
      if (wdata[B_INIT]) begin
        nxt[B_INIT] = 1'b1;
        nxt[B_STOP] = 1'b0;
      end
      if (wdata[B_STOP]) begin
        nxt[B_STOP] = 1'b1;
        nxt[B_STRT] = 1'b0;
        nxt[B_INIT] = 1'b0;
      end
      nxt[B_INEA] = wdata[B_INEA];
    end
    nxt = nxt | (evt_vec & EVT_MASK);
    if (init_done && nxt[B_INIT]) begin
      nxt[B_IDON] = 1'b1;
      nxt[B_INIT] = 1'b0;
      nxt[B_RXON] = ~mode[0];
      nxt[B_TXON] = ~mode[1];
    end
    if (nxt[B_MERR]) begin
      nxt[B_RXON] = 1'b0;
      nxt[B_TXON] = 1'b0;
    end
    if (nxt[B_STOP])
      nxt[B_IDON] = 1'b0;
    nxt[B_ERR]  = nxt[B_BABL] | nxt[B_CERR] | nxt[B_MISS] | nxt[B_MERR];
    nxt[B_INTR] = nxt[B_BABL] | nxt[B_MISS] | nxt[B_MERR] |
                  nxt[B_RINT] | nxt[B_TINT] | nxt[B_IDON];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q <= CSR0_RESET;
      irq_q <= 1'b0;
    end else begin
      csr_q <= nxt;
      irq_q <= nxt[B_INTR] & nxt[B_INEA];
    end
  end
endmodule

// File: rtl/nic_csr_aux_file.sv
`timescale 1ns/1ps
module nic_csr_aux_file #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [SEL_W-1:0]  sel_q,
  output logic [DATA_W-1:0] aux_rd
);
  logic [NUM_REGS-1:1][DATA_W-1:0] aux_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      aux_q <= '0;
    end else begin
      if (sel_wr)
        sel_q <= wdata[SEL_W-1:0];
      for (int i = 1; i < NUM_REGS; i++)
        if (data_wr && sel_q == SEL_W'(i))
          aux_q[i] <= wdata;
    end
  end

  always_comb begin
    aux_rd = '0;
    for (int i = 1; i < NUM_REGS; i++)
      if (sel_q == SEL_W'(i))
        aux_rd = aux_q[i];
  end
endmodule

// File: rtl/nic_csr_readback.sv
`timescale 1ns/1ps
module nic_csr_readback #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] csr0,
  input  logic [DATA_W-1:0] aux_rd,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] mux;

  always_comb begin
    if (addr)
      mux = DATA_W'(sel);
    else if (sel == '0)
      mux = csr0;
    else
      mux = aux_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= mux;
  end
endmodule

// File: rtl/nic_csr_block.sv
`timescale 1ns/1ps
module nic_csr_block
  import nic_csr_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_addr,
  input  logic             bus_we,
  input  logic [CSR_W-1:0] bus_wdata,
  output logic [CSR_W-1:0] bus_rdata,
  input  logic             evt_babble,
  input  logic             evt_coll_err,
  input  logic             evt_missed,
  input  logic             evt_mem_err,
  input  logic             evt_rx_done,
  input  logic             evt_tx_done,
  input  logic             evt_init_done,
  input  logic             evt_poll_ack,
  input  logic [1:0]       init_mode,
  output logic             cmd_start,
  output logic             cmd_init,
  output logic             cmd_tx_demand,
  output logic             stopped,
  output logic             rx_enable,
  output logic             tx_enable,
  output logic             irq
);
  logic [SEL_W-1:0] sel_q;
  logic [CSR_W-1:0] aux_rd;
  logic [CSR_W-1:0] csr_q;
  logic [CSR_W-1:0] evt_vec;
  logic             sel_wr, data_wr_aux, data_wr_csr0;

  assign sel_wr       = bus_we &  bus_addr;
  assign data_wr_csr0 = bus_we & ~bus_addr & (sel_q == '0);
  assign data_wr_aux  = bus_we & ~bus_addr & (sel_q != '0);

  always_comb begin
    evt_vec          = '0;
    evt_vec[B_BABL]  = evt_babble;
    evt_vec[B_CERR]  = evt_coll_err;
    evt_vec[B_MISS]  = evt_missed;
    evt_vec[B_MERR]  = evt_mem_err;
    evt_vec[B_RINT]  = evt_rx_done;
    evt_vec[B_TINT]  = evt_tx_done;
  end

  nic_csr_aux_file #(.DATA_W(CSR_W), .NUM_REGS(NUM_REGS)) u_aux (
    .clk(clk), .rst(rst), .sel_wr(sel_wr), .data_wr(data_wr_aux),
    .wdata(bus_wdata), .sel_q(sel_q), .aux_rd(aux_rd)
  );

  nic_csr_primary u_primary (
    .clk(clk), .rst(rst), .wr_en(data_wr_csr0), .wdata(bus_wdata),
    .evt_vec(evt_vec), .init_done(evt_init_done), .poll_ack(evt_poll_ack),
    .mode(init_mode), .csr_q(csr_q), .irq_q(irq)
  );

  nic_csr_readback #(.DATA_W(CSR_W), .SEL_W(SEL_W)) u_rb (
    .clk(clk), .rst(rst), .addr(bus_addr), .sel(sel_q), .csr0(csr_q),
    .aux_rd(aux_rd), .rdata_q(bus_rdata)
  );

  assign cmd_start     = csr_q[B_STRT];
  assign cmd_init      = csr_q[B_INIT];
  assign cmd_tx_demand = csr_q[B_TDMD];
  assign stopped       = csr_q[B_STOP];
  assign rx_enable     = csr_q[B_RXON];
  assign tx_enable     = csr_q[B_TXON];
endmodule

// File: rtl/nic_csr_checker.sv
`timescale 1ns/1ps
module nic_csr_checker
  import nic_csr_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_addr,
  input logic             bus_we,
  input logic [CSR_W-1:0] bus_wdata,
  input logic [CSR_W-1:0] bus_rdata,
  input logic             evt_rx_done,
  input logic [SEL_W-1:0] sel,
  input logic [CSR_W-1:0] csr,
  input logic             rx_enable,
  input logic             tx_enable,
  input logic             irq
);
  logic csr0_wr;
  assign csr0_wr = bus_we && !bus_addr && sel == '0;

  assert_sel_load_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr) |=> sel == $past(bus_wdata[SEL_W-1:0]));

  assert_reset_value_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (csr == CSR0_RESET && !irq));

  assert_w1c_rint_R4: assert property (@(posedge clk) disable iff (rst)
    (csr0_wr && bus_wdata[B_RINT] && !evt_rx_done) |=> !csr[B_RINT]);

  assert_stop_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (csr0_wr && bus_wdata[B_STOP]) |=> (csr[B_STOP] && !csr[B_STRT] && !csr[B_INIT]));

  assert_inea_follows_R7: assert property (@(posedge clk) disable iff (rst)
    csr0_wr |=> csr[B_INEA] == $past(bus_wdata[B_INEA]));

  assert_err_summary_R8: assert property (@(posedge clk) disable iff (rst)
    csr[B_ERR] == (csr[B_BABL] | csr[B_CERR] | csr[B_MISS] | csr[B_MERR]));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (csr[B_INTR] && csr[B_INEA]));

  assert_merr_off_R11: assert property (@(posedge clk) disable iff (rst)
    csr[B_MERR] |-> (!rx_enable && !tx_enable));

  assert_stop_idon_R11: assert property (@(posedge clk) disable iff (rst)
    csr[B_STOP] |-> !csr[B_IDON]);

  assert_sel_readback_R12: assert property (@(posedge clk) disable iff (rst)
    bus_addr |=> bus_rdata == CSR_W'($past(sel)));
endmodule

bind nic_csr_block nic_csr_checker #(.SEL_W(SEL_W)) u_checker (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_rx_done(evt_rx_done),
  .sel(sel_q), .csr(csr_q), .rx_enable(rx_enable), .tx_enable(tx_enable),
  .irq(irq)
);

// File: tb/test_nic_csr_block.sv
`timescale 1ns/1ps
module test_nic_csr_block;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_addr = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        evt_babble = 0, evt_coll_err = 0, evt_missed = 0, evt_mem_err = 0;
  logic        evt_rx_done = 0, evt_tx_done = 0, evt_init_done = 0, evt_poll_ack = 0;
  logic [1:0]  init_mode = '0;
  logic        cmd_start, cmd_init, cmd_tx_demand, stopped, rx_enable, tx_enable, irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state: stored bits of register 0 (without summaries)
  int m_csr, m_sel, m_irq, exp_rd;
  int m_aux[4];

  always #10 clk = ~clk;

  nic_csr_block i_nic_csr_block (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_babble(evt_babble), .evt_coll_err(evt_coll_err), .evt_missed(evt_missed),
    .evt_mem_err(evt_mem_err), .evt_rx_done(evt_rx_done), .evt_tx_done(evt_tx_done),
    .evt_init_done(evt_init_done), .evt_poll_ack(evt_poll_ack), .init_mode(init_mode),
    .cmd_start(cmd_start), .cmd_init(cmd_init), .cmd_tx_demand(cmd_tx_demand),
    .stopped(stopped), .rx_enable(rx_enable), .tx_enable(tx_enable), .irq(irq)
  );

  function automatic int bitv(int v, int p);
    return (v >> p) & 1;
  endfunction

  function automatic int visible(int c);
    int r = c & 16'h7F7F;
    if ((c & 16'h7800) != 0) r |= 16'h8000;            // ERR from BABL/CERR/MISS/MERR
    if ((c & 16'h5F00) != 0) r |= 16'h0080;            // INTR, CERR excluded
    return r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  // ev: [0]babble [1]coll [2]missed [3]memerr [4]rx [5]tx [6]initdone [7]pollack
  task automatic model_step(int a, int we, int wd, int ev, int md);
    exp_rd = (a != 0) ? m_sel : ((m_sel == 0) ? visible(m_csr) : m_aux[m_sel]);
    if (bitv(ev, 7) != 0) m_csr &= ~(1 << 3);
    if (we != 0 && a != 0) m_sel = wd & 3;
    else if (we != 0 && m_sel != 0) m_aux[m_sel] = wd & 16'hFFFF;
    else if (we != 0) begin
      m_csr &= ~(wd & 16'h7F00);
      if (bitv(wd, 3) != 0) m_csr |= 8;
      if (bitv(wd, 1) != 0) m_csr = (m_csr | 2) & ~4;
      if (bitv(wd, 0) != 0) m_csr = (m_csr | 1) & ~4;
      if (bitv(wd, 2) != 0) m_csr = (m_csr | 4) & ~3;
      m_csr = (m_csr & ~16'h40) | (wd & 16'h40);
    end
    for (int k = 0; k < 6; k++)
      if (bitv(ev, k) != 0) m_csr |= 1 << (14 - k);
    if (bitv(ev, 6) != 0 && bitv(m_csr, 0) != 0) begin
      m_csr = (m_csr | 16'h0100) & ~1;
      m_csr = (m_csr & ~16'h30) | ((bitv(md, 0) == 0) ? 16'h20 : 0) | ((bitv(md, 1) == 0) ? 16'h10 : 0);
    end
    if (bitv(m_csr, 11) != 0) m_csr &= ~16'h30;
    if (bitv(m_csr, 2) != 0) m_csr &= ~16'h100;
    m_irq = bitv(visible(m_csr), 7) & bitv(m_csr, 6);
  endtask

  task automatic step(int a, int we, int wd, int ev, int md);
    bus_addr = a[0]; bus_we = we[0]; bus_wdata = wd[15:0]; init_mode = md[1:0];
    {evt_poll_ack, evt_init_done, evt_tx_done, evt_rx_done,
     evt_mem_err, evt_missed, evt_coll_err, evt_babble} = ev[7:0];
    @(posedge clk); #2;
    model_step(a, we, wd, ev, md);
    chk("R12 rdata", int'(bus_rdata), exp_rd);
    chk("R9 irq", int'(irq), m_irq);
    chk("R5 cmd_start", int'(cmd_start), bitv(m_csr, 1));
    chk("R5 cmd_init", int'(cmd_init), bitv(m_csr, 0));
    chk("R5 cmd_tx_demand", int'(cmd_tx_demand), bitv(m_csr, 3));
    chk("R6 stopped", int'(stopped), bitv(m_csr, 2));
    chk("R10 rx_enable", int'(rx_enable), bitv(m_csr, 5));
    chk("R10 tx_enable", int'(tx_enable), bitv(m_csr, 4));
    @(negedge clk);
    bus_we = 0; {evt_poll_ack, evt_init_done, evt_tx_done, evt_rx_done,
                 evt_mem_err, evt_missed, evt_coll_err, evt_babble} = '0;
  endtask

  // read location a, check the value shown one cycle later
  task automatic rd(int a, string tag, int exp);
    step(a, 0, 0, 0, 0);
    chk(tag, int'(bus_rdata), exp);
  endtask

  initial begin
    m_csr = 16'h0004; m_sel = 0; m_irq = 0;
    for (int k = 0; k < 4; k++) m_aux[k] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R3 irq after reset", int'(irq), 0);
    rd(0, "R3 reset value", 16'h0004);
    // pointer and storage
    step(1, 1, 16'hFFFE, 0, 0);
    step(0, 1, 16'hBEEF, 0, 0);
    step(1, 1, 16'h0007, 0, 0);
    step(0, 1, 16'h1234, 0, 0);
    rd(1, "R1 pointer low bits", 3);
    rd(0, "R2 reg3 storage", 16'h1234);
    step(1, 1, 16'h0002, 0, 0);
    rd(0, "R2 reg2 storage", 16'hBEEF);
    step(1, 1, 16'h0005, 0, 0);
    rd(0, "R2 reg1 reset zero", 0);
    step(1, 1, 16'h0004, 0, 0);
    rd(0, "R1 pointer truncates to reg0", 16'h0004);
    // commands
    step(0, 1, 16'h0003, 0, 0);
    rd(0, "R5 strt/init set clears stop", 16'h0003);
    step(0, 1, 16'h0000, 0, 0);
    rd(0, "R5 zero write keeps commands", 16'h0003);
    step(0, 0, 0, 8'h40, 2'b10);
    rd(0, "R10 init done tx disabled", 16'h01A2);
    chk("R9 irq masked by inea", int'(irq), 0);
    step(0, 1, 16'h0040, 0, 0);
    chk("R7 inea raises irq", int'(irq), 1);
    step(0, 1, 16'h0140, 0, 0);
    chk("R9 irq drops with idon", int'(irq), 0);
    rd(0, "R4 idon cleared", 16'h0062);
    step(0, 0, 0, 8'h02, 0);
    rd(0, "R8 cerr sets err only", 16'hA062);
    chk("R9 cerr not in intr", int'(irq), 0);
    step(0, 1, 16'h2040, 8'h10, 0);
    rd(0, "R4 clear cerr with rint event", 16'h04E2);
    step(0, 1, 16'h0440, 8'h10, 0);
    rd(0, "R4 event beats clear", 16'h04E2);
    step(0, 1, 16'h0440, 0, 0);
    rd(0, "R4 rint cleared", 16'h0062);
    step(0, 1, 16'h0048, 0, 0);
    step(0, 1, 16'h0040, 0, 0);
    rd(0, "R5 tdmd not cleared by write", 16'h006A);
    step(0, 0, 0, 8'h80, 0);
    rd(0, "R5 poll ack clears tdmd", 16'h0062);
    step(0, 0, 0, 8'h08, 0);
    rd(0, "R11 merr forces rx off", 16'h88C2);
    step(0, 1, 16'h0840, 0, 0);
    step(0, 1, 16'h80F0, 0, 0);
    rd(0, "R8 read-only bits ignore write", 16'h0042);
    step(0, 1, 16'h0041, 0, 0);
    step(0, 0, 0, 8'h40, 2'b00);
    rd(0, "R10 init done both on", 16'h01F2);
    step(0, 1, 16'h0047, 0, 0);
    rd(0, "R6 stop wins R11 idon cleared", 16'h0074);
    step(0, 0, 0, 8'h40, 2'b11);
    rd(0, "R10 init done ignored without init", 16'h0074);
    step(0, 0, 0, 8'h31, 0);
    rd(0, "R9 events while stopped", 16'hC6F4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule